// File: doc/BRIEF.md
# Serial NOR Flash Probe and Unprotect Sequencer

This block runs a one-shot bring-up routine for a serial NOR flash attached through a byte-wide SPI master. When it is started after reset, it frames an identification transaction on chip select. The reply has three bytes: the vendor code, the device family code and a size code. The block checks the first two against fixed expected values. It then turns the size code into the geometry that the software layer above needs: how many 4 KiB erase sectors there are, how many 256-byte program pages there are, and the two size shifts.

If the identity is accepted, the block sends three further one-byte commands, each in its own chip-select frame. These set the write latch, clear the power-on global block protection, and clear the write latch again. It then raises `ready_o` and shows the geometry. If the identity is rejected, it sends nothing more and raises `error_o`. Both outcomes last until the next reset.

The bit-level shifter is outside this block. It sits behind a request/acknowledge byte port. The block holds `spi_req_o` and `spi_tx_o` until the shifter returns `spi_ack_i` for one cycle with the received byte on `spi_rx_i`.

Top module: `nor_id_sequencer`

## Requirements
- R1: While reset is held, `spi_cs_n_o` is 1, and `spi_req_o`, `ready_o` and `error_o` are 0. All geometry outputs are 0.
- R2: After `start_i`, the first chip-select frame carries exactly four bytes. They are 0x9F, then three fill bytes of 0xA5. The bytes received in positions 1, 2 and 3 are taken as the vendor, family and size codes.
- R3: The identity is accepted only when all three hold: the vendor code is 0xBF, the family code is 0x26, and the size code is 0x41, 0x42 or 0x43. The size codes give 512/8192, 1024/16384 and 2048/32768 sectors/pages respectively.
- R4: While `ready_o` is 1, `sector_shift_o` is 12 and `page_shift_o` is 8. While `ready_o` is 0, all geometry outputs are 0.
- R5: On acceptance, exactly three more frames follow, each one byte long, in this order: 0x06, 0x98, 0x04. `ready_o` rises only after the last of these frames has closed.
- R6: On rejection, no frame follows the identification frame, and `error_o` rises.
- R7: Before every frame, including the first, `spi_cs_n_o` stays 1 for at least GAP_CYCLES (default 4) consecutive clock cycles. `spi_req_o` is 1 only while `spi_cs_n_o` is 0.
- R8: `ready_o` and `error_o` are never 1 together. Once either is set, it stays unchanged until reset.
- R9: `start_i` has no effect while the routine is running or after it has finished. Each reset period produces exactly one identification frame.
- R10: Once `spi_req_o` is raised for a byte, it stays 1 and `spi_tx_o` stays unchanged until the cycle in which `spi_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts the probe; seen only in the idle state |
| spi_cs_n_o | output | 1 | Flash chip select, active low |
| spi_req_o | output | 1 | Byte transfer request to the shifter |
| spi_tx_o | output | 8 | Byte to transmit |
| spi_ack_i | input | 1 | One-cycle transfer-complete strobe from the shifter |
| spi_rx_i | input | 8 | Byte received; valid together with spi_ack_i |
| ready_o | output | 1 | Device accepted and unprotected; sticky |
| error_o | output | 1 | Device rejected; sticky |
| nsectors_o | output | 12 | Number of 4 KiB erase sectors |
| npages_o | output | 16 | Number of 256-byte program pages |
| sector_shift_o | output | 5 | log2 of the sector size |
| page_shift_o | output | 5 | log2 of the page size |

## Verification
The assertions assume that the shifter raises `spi_ack_i` for one cycle at a time, and only while `spi_req_o` is 1. They also assume that reset is applied only while the flash port is idle. The bench's shifter model keeps to this. It waits at a falling edge for a request, adds a random latency of zero to three cycles, and drives a single-cycle acknowledge. Reset is pulsed only between complete probes. Extra `start_i` pulses are injected at random both during and after a run. They only ever reach the block's input, so they cannot break the handshake that the assertions depend on.

// File: rtl/nor_id_pkg.sv
// Package nor_id_pkg
// Holds the shared command bytes and the state encodings for the flash
// probe sequencer and its helper blocks.
package nor_id_pkg;

    localparam logic [7:0] OP_READ_ID   = 8'h9F;
    localparam logic [7:0] FILL_BYTE    = 8'hA5;
    localparam logic [7:0] OP_WR_EN     = 8'h06;
    localparam logic [7:0] OP_UNPROTECT = 8'h98;
    localparam logic [7:0] OP_WR_DIS    = 8'h04;

    // Opcode plus three reply slots
    localparam int ID_FRAME_BYTES = 4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ID,
        SQ_CHECK,
        SQ_WREN,
        SQ_UNLK,
        SQ_WRDI,
        SQ_READY,
        SQ_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_GAP,
        FR_SHIFT
    } frame_state_t;

endpackage

// File: rtl/nor_id_framer.sv
// Module nor_id_framer
// Frames one chip-select transaction of 1..MAX_BYTES bytes on the byte
// handshake port. On go_i it first keeps chip select high for GAP_CYCLES
// cycles, then drops chip select and requests each byte in turn. After the
// final acknowledge it raises chip select again and pulses done_o.
// Assumes: spi_ack_i is a one-cycle strobe that arrives only while req_o is
// high. go_i is only honoured in the idle state.
module nor_id_framer
    import nor_id_pkg::*;
#(
    parameter int GAP_CYCLES = 4,
    parameter int MAX_BYTES  = 4,
    localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    localparam int CNT_W = $clog2(GAP_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [IDX_W:0]   nbytes_i,
    input  logic [7:0]       tx_i,
    input  logic             spi_ack_i,
    output logic             cs_n_o,
    output logic             req_o,
    output logic [7:0]       tx_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             rx_valid_o,
    output logic             done_o
);

    frame_state_t     state_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // Frame state machine: idle -> chip-select-high gap -> byte shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            idx_q   <= '0;
            last_q  <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                FR_IDLE: begin
                    if (go_i) begin
                        last_q  <= IDX_W'(nbytes_i - 1'b1);
                        idx_q   <= '0;
                        cnt_q   <= '0;
                        state_q <= FR_GAP;
                    end
                end
                FR_GAP: begin
                    if (cnt_q == CNT_W'(GAP_CYCLES - 1)) begin
                        state_q <= FR_SHIFT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                FR_SHIFT: begin
                    if (spi_ack_i) begin
                        if (idx_q == last_q) begin
                            state_q <= FR_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= FR_IDLE;
            endcase
        end
    end

    // Port drive: chip select and request are both decoded from the shift state
    always_comb begin
        cs_n_o     = (state_q != FR_SHIFT);
        req_o      = (state_q == FR_SHIFT);
        tx_o       = tx_i;
        idx_o      = idx_q;
        rx_valid_o = (state_q == FR_SHIFT) && spi_ack_i;
        done_o     = done_q;
    end

    // Checker: counts consecutive chip-select-high cycles, saturating at the gap
    logic [CNT_W:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run_q <= '0;
        end else if (!cs_n_o) begin
            hi_run_q <= '0;
        end else if (hi_run_q < (CNT_W + 1)'(GAP_CYCLES)) begin
            hi_run_q <= hi_run_q + 1'b1;
        end
    end

    p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (hi_run_q >= (CNT_W + 1)'(GAP_CYCLES)));

    p_req_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> !cs_n_o);

    p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !spi_ack_i) |=> (req_o && $stable(tx_o)));

endmodule

// File: rtl/nor_id_decode.sv
// Module nor_id_decode
// Captures the three identification reply bytes as they arrive. Checks the
// vendor and family codes, and turns the size code into sector and page
// counts. Each supported size code doubles the one below it.
// Assumes: rx_valid_i marks a received byte and idx_i is its position
// within the identification frame.
module nor_id_decode #(
    parameter logic [7:0] MFR_ID       = 8'hBF,
    parameter logic [7:0] MEM_TYPE     = 8'h26,
    parameter logic [7:0] CAP_BASE     = 8'h41,
    parameter int         NUM_SIZES    = 3,
    parameter int         BASE_SECTORS = 512,
    parameter int         SECTOR_SHIFT = 12,
    parameter int         PAGE_SHIFT   = 8,
    parameter int         IDX_W        = 2,
    localparam int SECT_W = $clog2(BASE_SECTORS) + NUM_SIZES,
    localparam int PAGE_W = SECT_W + SECTOR_SHIFT - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en_i,
    input  logic              rx_valid_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [7:0]        rx_i,
    output logic              id_ok_o,
    output logic [SECT_W-1:0] sectors_o,
    output logic [PAGE_W-1:0] pages_o
);

    logic [7:0] mfr_q;
    logic [7:0] typ_q;
    logic [7:0] cap_q;

    // Reply capture: byte positions 1, 2 and 3 hold vendor, family and size
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mfr_q <= '0;
            typ_q <= '0;
            cap_q <= '0;
        end else if (cap_en_i && rx_valid_i) begin
            if (idx_i == IDX_W'(1)) mfr_q <= rx_i;
            if (idx_i == IDX_W'(2)) typ_q <= rx_i;
            if (idx_i == IDX_W'(3)) cap_q <= rx_i;
        end
    end

    logic [NUM_SIZES-1:0] hit;
    logic [SECT_W-1:0]    sect_opt [NUM_SIZES];
    logic [PAGE_W-1:0]    page_opt [NUM_SIZES];

    // One comparator and one geometry constant for each supported size code
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        assign hit[g]      = (cap_q == 8'(int'(CAP_BASE) + g));
        assign sect_opt[g] = hit[g] ? (SECT_W'(BASE_SECTORS) << g) : '0;
        assign page_opt[g] = hit[g] ?
            (PAGE_W'(BASE_SECTORS) << (g + SECTOR_SHIFT - PAGE_SHIFT)) : '0;
    end

    // Merge the size options and qualify the identity
    always_comb begin
        sectors_o = '0;
        pages_o   = '0;
        for (int k = 0; k < NUM_SIZES; k++) begin
            sectors_o = sectors_o | sect_opt[k];
            pages_o   = pages_o | page_opt[k];
        end
        id_ok_o = (mfr_q == MFR_ID) && (typ_q == MEM_TYPE) && (|hit);
    end

endmodule

// File: rtl/nor_id_sequencer.sv
// Module nor_id_sequencer
// Top of the flash probe. On start it runs the identification frame, checks
// the reply, and then either sends the unprotect command trio and reports
// ready with the geometry, or reports error. The routine runs once per reset.
// Assumes: the byte shifter behind spi_req_o/spi_ack_i gives one
// acknowledge per requested byte.
module nor_id_sequencer
    import nor_id_pkg::*;
#(
    parameter int         GAP_CYCLES   = 4,
    parameter logic [7:0] MFR_ID       = 8'hBF,
    parameter logic [7:0] MEM_TYPE     = 8'h26,
    parameter logic [7:0] CAP_BASE     = 8'h41,
    parameter int         NUM_SIZES    = 3,
    parameter int         BASE_SECTORS = 512,
    parameter int         SECTOR_SHIFT = 12,
    parameter int         PAGE_SHIFT   = 8,
    localparam int SECT_W  = $clog2(BASE_SECTORS) + NUM_SIZES,
    localparam int PAGE_W  = SECT_W + SECTOR_SHIFT - PAGE_SHIFT,
    localparam int SHIFT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    output logic               spi_cs_n_o,
    output logic               spi_req_o,
    output logic [7:0]         spi_tx_o,
    input  logic               spi_ack_i,
    input  logic [7:0]         spi_rx_i,
    output logic               ready_o,
    output logic               error_o,
    output logic [SECT_W-1:0]  nsectors_o,
    output logic [PAGE_W-1:0]  npages_o,
    output logic [SHIFT_W-1:0] sector_shift_o,
    output logic [SHIFT_W-1:0] page_shift_o
);

    localparam int IDX_W = $clog2(ID_FRAME_BYTES);

    seq_state_t        state_q;
    seq_state_t        state_d;
    logic              fr_go;
    logic [IDX_W:0]    fr_nbytes;
    logic [7:0]        fr_tx;
    logic [IDX_W-1:0]  fr_idx;
    logic              fr_rx_valid;
    logic              fr_done;
    logic              id_ok;
    logic [SECT_W-1:0] dec_sectors;
    logic [PAGE_W-1:0] dec_pages;
    logic [SECT_W-1:0] sect_q;
    logic [PAGE_W-1:0] page_q;

    nor_id_framer #(
        .GAP_CYCLES (GAP_CYCLES),
        .MAX_BYTES  (ID_FRAME_BYTES)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (fr_go),
        .nbytes_i   (fr_nbytes),
        .tx_i       (fr_tx),
        .spi_ack_i  (spi_ack_i),
        .cs_n_o     (spi_cs_n_o),
        .req_o      (spi_req_o),
        .tx_o       (spi_tx_o),
        .idx_o      (fr_idx),
        .rx_valid_o (fr_rx_valid),
        .done_o     (fr_done)
    );

    nor_id_decode #(
        .MFR_ID       (MFR_ID),
        .MEM_TYPE     (MEM_TYPE),
        .CAP_BASE     (CAP_BASE),
        .NUM_SIZES    (NUM_SIZES),
        .BASE_SECTORS (BASE_SECTORS),
        .SECTOR_SHIFT (SECTOR_SHIFT),
        .PAGE_SHIFT   (PAGE_SHIFT),
        .IDX_W        (IDX_W)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en_i   (state_q == SQ_ID),
        .rx_valid_i (fr_rx_valid),
        .idx_i      (fr_idx),
        .rx_i       (spi_rx_i),
        .id_ok_o    (id_ok),
        .sectors_o  (dec_sectors),
        .pages_o    (dec_pages)
    );

    // Next-state logic and frame launch for each step of the routine
    always_comb begin
        state_d   = state_q;
        fr_go     = 1'b0;
        fr_nbytes = (IDX_W + 1)'(1);
        case (state_q)
            SQ_IDLE: begin
                if (start_i) begin
                    fr_go     = 1'b1;
                    fr_nbytes = (IDX_W + 1)'(ID_FRAME_BYTES);
                    state_d   = SQ_ID;
                end
            end
            SQ_ID:    if (fr_done) state_d = SQ_CHECK;
            SQ_CHECK: begin
                if (id_ok) begin
                    fr_go   = 1'b1;
                    state_d = SQ_WREN;
                end else begin
                    state_d = SQ_FAIL;
                end
            end
            SQ_WREN: begin
                if (fr_done) begin
                    fr_go   = 1'b1;
                    state_d = SQ_UNLK;
                end
            end
            SQ_UNLK: begin
                if (fr_done) begin
                    fr_go   = 1'b1;
                    state_d = SQ_WRDI;
                end
            end
            SQ_WRDI:  if (fr_done) state_d = SQ_READY;
            default:  state_d = state_q;
        endcase
    end

    // Byte to send, chosen by the current step and the position in the frame
    always_comb begin
        case (state_q)
            SQ_ID:   fr_tx = (fr_idx == '0) ? OP_READ_ID : FILL_BYTE;
            SQ_WREN: fr_tx = OP_WR_EN;
            SQ_UNLK: fr_tx = OP_UNPROTECT;
            SQ_WRDI: fr_tx = OP_WR_DIS;
            default: fr_tx = FILL_BYTE;
        endcase
    end

    // State register, and geometry latched at the moment the identity is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            sect_q  <= '0;
            page_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SQ_CHECK && id_ok) begin
                sect_q <= dec_sectors;
                page_q <= dec_pages;
            end
        end
    end

    // Result outputs; geometry is shown only while ready
    always_comb begin
        ready_o        = (state_q == SQ_READY);
        error_o        = (state_q == SQ_FAIL);
        nsectors_o     = ready_o ? sect_q : '0;
        npages_o       = ready_o ? page_q : '0;
        sector_shift_o = ready_o ? SHIFT_W'(SECTOR_SHIFT) : '0;
        page_shift_o   = ready_o ? SHIFT_W'(PAGE_SHIFT) : '0;
    end

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_o && error_o));

    p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> (ready_o && !error_o));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |=> (error_o && !ready_o));

    p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_CHECK && !id_ok) |=> error_o);

    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> (spi_cs_n_o && !spi_req_o));

    p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (sector_shift_o == SHIFT_W'(SECTOR_SHIFT) &&
                     page_shift_o == SHIFT_W'(PAGE_SHIFT)));

    p_geom_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (nsectors_o == '0 && npages_o == '0));

endmodule

// File: tb/nor_id_sequencer_bench.sv
// Bench for nor_id_sequencer. A shifter model replies with a chosen
// identity, random acknowledge latency and stray start pulses. Each probe
// is checked against expectations computed here from the requirements.
module nor_id_sequencer_bench;

    localparam int GAP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        spi_cs_n_o;
    logic        spi_req_o;
    logic [7:0]  spi_tx_o;
    logic        spi_ack_i = 1'b0;
    logic [7:0]  spi_rx_i = 8'h00;
    logic        ready_o;
    logic        error_o;
    logic [11:0] nsectors_o;
    logic [15:0] npages_o;
    logic [4:0]  sector_shift_o;
    logic [4:0]  page_shift_o;

    int checks = 0;
    int fails  = 0;

    logic [7:0] id_m, id_t, id_c;
    logic [7:0] frame_bytes [8][8];
    int         frame_len [8];
    int         nframes;
    int         gap_bad;
    int         req_bad;
    int         hi_cnt;
    logic       prev_cs;

    always #4 clk = ~clk;

    nor_id_sequencer u_nor_id_sequencer (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .spi_cs_n_o     (spi_cs_n_o),
        .spi_req_o      (spi_req_o),
        .spi_tx_o       (spi_tx_o),
        .spi_ack_i      (spi_ack_i),
        .spi_rx_i       (spi_rx_i),
        .ready_o        (ready_o),
        .error_o        (error_o),
        .nsectors_o     (nsectors_o),
        .npages_o       (npages_o),
        .sector_shift_o (sector_shift_o),
        .page_shift_o   (page_shift_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit id_valid(input logic [7:0] m, input logic [7:0] t,
                                    input logic [7:0] c);
        return (m == 8'hBF) && (t == 8'h26) && (c >= 8'h41) && (c <= 8'h43);
    endfunction

    function automatic int exp_sectors(input logic [7:0] c);
        return 512 << (int'(c) - 'h41);
    endfunction

    function automatic int exp_pages(input logic [7:0] c);
        return 8192 << (int'(c) - 'h41);
    endfunction

    function automatic logic [7:0] reply_byte(input int b);
        if (nframes != 0) return 8'h00;
        case (b)
            1:       return id_m;
            2:       return id_t;
            3:       return id_c;
            default: return 8'hFF;
        endcase
    endfunction

    // Shifter model: one-cycle acknowledge after a random latency; logs sent bytes
    initial begin
        forever begin
            @(negedge clk);
            if (spi_req_o && !spi_cs_n_o) begin
                repeat ($urandom % 4) @(negedge clk);
                if (nframes < 8 && frame_len[nframes] < 8) begin
                    frame_bytes[nframes][frame_len[nframes]] = spi_tx_o;
                end
                spi_rx_i  = reply_byte(frame_len[nframes]);
                if (nframes < 8) frame_len[nframes] = frame_len[nframes] + 1;
                spi_ack_i = 1'b1;
                @(negedge clk);
                spi_ack_i = 1'b0;
            end
        end
    end

    // Monitor: frame boundaries, chip-select-high gap, request outside frame
    initial begin
        prev_cs = 1'b1;
        hi_cnt  = 0;
        forever begin
            @(negedge clk);
            if (spi_cs_n_o) begin
                if (!prev_cs && nframes < 7) nframes++;
                hi_cnt++;
            end else begin
                if (prev_cs && hi_cnt < GAP) gap_bad++;
                hi_cnt = 0;
            end
            if (spi_req_o && spi_cs_n_o) req_bad++;
            prev_cs = spi_cs_n_o;
        end
    end

    task automatic run_trial(input logic [7:0] m, input logic [7:0] t,
                             input logic [7:0] c);
        bit   ok;
        int   cyc;
        logic r0, e0;
        ok = id_valid(m, t, c);
        rst_n   = 1'b0;
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(spi_cs_n_o === 1'b1, "R1", "cs_n in reset", int'(spi_cs_n_o), 1);
        chk(spi_req_o === 1'b0 && ready_o === 1'b0 && error_o === 1'b0,
            "R1", "req/ready/error in reset",
            int'({spi_req_o, ready_o, error_o}), 0);
        chk(nsectors_o === '0 && npages_o === '0, "R1", "geometry in reset",
            int'(nsectors_o), 0);
        nframes = 0;
        gap_bad = 0;
        req_bad = 0;
        for (int f = 0; f < 8; f++) frame_len[f] = 0;
        id_m = m;
        id_t = t;
        id_c = c;
        rst_n = 1'b1;
        repeat ($urandom % 5) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (!(ready_o || error_o) && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            start_i = (($urandom % 16) == 0);
        end
        start_i = 1'b0;
        chk(cyc < 3000, "R8", "probe finished", cyc, 0);
        r0 = ready_o;
        e0 = error_o;
        for (int p = 0; p < 2; p++) begin
            @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (20) @(negedge clk);
        end
        chk(ready_o === r0 && error_o === e0, "R8", "result sticky",
            int'({ready_o, error_o}), int'({r0, e0}));
        chk(!(ready_o && error_o), "R8", "ready and error exclusive",
            int'({ready_o, error_o}), int'({ok, !ok}));
        chk(ready_o === ok, "R3", "ready vs identity", int'(ready_o), int'(ok));
        chk(error_o === !ok, "R6", "error vs identity", int'(error_o), int'(!ok));
        chk(nframes == (ok ? 4 : 1), "R9", "frame count", nframes, ok ? 4 : 1);
        chk(frame_len[0] == 4, "R2", "id frame length", frame_len[0], 4);
        chk(frame_bytes[0][0] == 8'h9F, "R2", "id opcode",
            int'(frame_bytes[0][0]), 'h9F);
        chk(frame_bytes[0][1] == 8'hA5 && frame_bytes[0][2] == 8'hA5 &&
            frame_bytes[0][3] == 8'hA5, "R2", "fill bytes",
            int'(frame_bytes[0][3]), 'hA5);
        chk(gap_bad == 0, "R7", "cs high gap violations", gap_bad, 0);
        chk(req_bad == 0, "R7", "request outside frame", req_bad, 0);
        if (ok) begin
            chk(frame_len[1] == 1 && frame_bytes[1][0] == 8'h06, "R5",
                "write enable frame", int'(frame_bytes[1][0]), 'h06);
            chk(frame_len[2] == 1 && frame_bytes[2][0] == 8'h98, "R5",
                "unprotect frame", int'(frame_bytes[2][0]), 'h98);
            chk(frame_len[3] == 1 && frame_bytes[3][0] == 8'h04, "R5",
                "write disable frame", int'(frame_bytes[3][0]), 'h04);
            chk(int'(nsectors_o) == exp_sectors(c), "R3", "sector count",
                int'(nsectors_o), exp_sectors(c));
            chk(int'(npages_o) == exp_pages(c), "R3", "page count",
                int'(npages_o), exp_pages(c));
            chk(sector_shift_o == 5'd12 && page_shift_o == 5'd8, "R4",
                "size shifts", int'({sector_shift_o, page_shift_o}),
                int'({5'd12, 5'd8}));
        end else begin
            chk(nsectors_o == '0 && npages_o == '0 && sector_shift_o == '0,
                "R4", "geometry zero on reject", int'(nsectors_o), 0);
        end
    endtask

    initial begin
        logic [7:0] m, t, c;
        void'($urandom(32'd20240611));
        run_trial(8'hBF, 8'h26, 8'h41);
        run_trial(8'hBF, 8'h26, 8'h42);
        run_trial(8'hBF, 8'h26, 8'h43);
        run_trial(8'hBF, 8'h26, 8'h40);
        run_trial(8'hBF, 8'h26, 8'h44);
        run_trial(8'hBE, 8'h26, 8'h42);
        run_trial(8'hBF, 8'h25, 8'h42);
        run_trial(8'h00, 8'h00, 8'h00);
        for (int i = 0; i < 30; i++) begin
            m = (($urandom % 4) != 0) ? 8'hBF : 8'($urandom);
            t = (($urandom % 4) != 0) ? 8'h26 : 8'($urandom);
            c = (($urandom % 4) != 0) ? 8'(8'h41 + ($urandom % 3)) : 8'($urandom);
            run_trial(m, t, c);
        end
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still reports
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks, fails);
        $finish;
    end

endmodule